// File: doc/BRIEF.md
# Packed Integer Compare-Select Unit

This unit evaluates `R = (A < B) ? C : D`, or the same shape with an equality or greater-than test, across every lane of a packed integer vector in one operation and without any branch. The vector is split into byte, halfword or word lanes according to a size code. Each lane of A is compared with the matching lane of B, and each lane produces a mask that is either all ones or all zeros.

The select is built from explicit mask arithmetic rather than from a per-lane multiplexer. C is ANDed with the mask, D is ANDed with the inverted mask, and the two partial results are ORed together. The mask itself is a second output, so a consumer can reuse it directly as a predicate vector.

A request is accepted on any cycle in which `in_valid` is high. The result and the mask are registered, and they are reported with `out_valid` exactly one cycle later.

Top module: `csel_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `out_mask` and `out_res` to zero at the next clock edge.
- R2: `out_valid` is high in the cycle after the edge at which `in_valid` was sampled high, and low after an edge at which `in_valid` was sampled low.
- R3: `lane_sz` sets the lane width: 0 gives 8 bits, 1 gives 16 bits, and both 2 and 3 give 32 bits. Every lane of `out_mask` is either all ones or all zeros.
- R4: With `cmp_op` 0 or 3, a lane's mask is all ones exactly when the A lane equals the B lane.
- R5: With `cmp_op` 1, a lane's mask is all ones exactly when the A lane is greater than the B lane, with both read as two's-complement signed values.
- R6: With `cmp_op` 2, a lane's mask is all ones exactly when the A lane is less than the B lane, read as signed values. This is the greater-than test with A and B swapped.
- R7: In every bit where `out_mask` is 1, `out_res` equals the C operand of the same request.
- R8: In every bit where `out_mask` is 0, `out_res` equals the D operand of the same request.
- R9: In a cycle where `in_valid` is low, the operand and code inputs have no effect: `out_mask` and `out_res` keep their previous values.
- R10: All lanes are evaluated independently in one operation. A lane's outcome depends only on its own A and B bits, so a carry or borrow never crosses a lane boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands and codes are captured when high |
| lane_sz | input | 2 | Lane width code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| cmp_op | input | 2 | Compare code: 0 or 3 = equal, 1 = signed greater, 2 = signed less |
| op_a | input | VEC_W | Left compare operand |
| op_b | input | VEC_W | Right compare operand |
| op_c | input | VEC_W | Value kept in lanes where the compare holds |
| op_d | input | VEC_W | Value kept in lanes where the compare fails |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_mask | output | VEC_W | Registered per-lane compare mask |
| out_res | output | VEC_W | Registered selected result |

## Verification
The bench builds the unit with `VEC_W` = 32. At that width, byte mode has four lanes, halfword mode has two and word mode has one, and the bench's expected values fit in plain 64-bit integer arithmetic. This lets the sweep cover every pairing of the four size codes with the four compare codes. Each pairing is driven with fixed sign-boundary values (0x7F/0x80, 0xFF/0x00, 0x7FFF/0x8000) and a stream of pseudo-random operands in which some bytes of B are copied from A. The copied bytes produce equal lanes in every mode, and they also produce lanes whose low byte matches while the high part differs, which exposes any carry that leaks between lanes.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int NUM_SIZES   = 3;
  localparam int BASE_LANE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } lane_sz_e;

  typedef enum logic [1:0] {
    OP_EQ   = 2'd0,
    OP_GT   = 2'd1,
    OP_LT   = 2'd2,
    OP_EALT = 2'd3
  } cmp_op_e;

  // equality codes are the two where both bits agree
  function automatic logic op_is_eq(input logic [1:0] op);
    return op[0] == op[1];
  endfunction

  // less-than reuses the greater-than path with operands exchanged
  function automatic logic op_swaps(input logic [1:0] op);
    return op == OP_LT;
  endfunction

  function automatic logic lane_hit(input logic signed [31:0] x,
                                    input logic signed [31:0] y,
                                    input logic eq_mode);
    return eq_mode ? (x == y) : (x > y);
  endfunction

endpackage

// File: rtl/csel_lane_cmp.sv
module csel_lane_cmp
  import csel_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] lhs,
  input  logic [VEC_W-1:0] rhs,
  input  logic             eq_mode,
  output logic [VEC_W-1:0] mask
);
  localparam int NUM_LANES = VEC_W / LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic signed [LANE_W-1:0] x_l;
    logic signed [LANE_W-1:0] y_l;
    logic                     hit;
    assign x_l = lhs[l*LANE_W +: LANE_W];
    assign y_l = rhs[l*LANE_W +: LANE_W];
    // sign-extend to the common compare width of the helper
    assign hit = lane_hit(32'(x_l), 32'(y_l), eq_mode);
    assign mask[l*LANE_W +: LANE_W] = {LANE_W{hit}};
  end

endmodule

// File: rtl/csel_mask_merge.sv
module csel_mask_merge #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] mask,
  input  logic [VEC_W-1:0] val_c,
  input  logic [VEC_W-1:0] val_d,
  output logic [VEC_W-1:0] kept_c,
  output logic [VEC_W-1:0] kept_d,
  output logic [VEC_W-1:0] merged
);
  assign kept_c = val_c & mask;
  assign kept_d = val_d & ~mask;
  assign merged = kept_c | kept_d;
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       lane_sz,
  input  logic [1:0]       cmp_op,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [VEC_W-1:0] op_c,
  input  logic [VEC_W-1:0] op_d,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_mask,
  output logic [VEC_W-1:0] out_res
);
  // VEC_W must be a multiple of the widest lane (32 bits)

  logic             eq_mode;
  logic             swap_ab;
  logic [VEC_W-1:0] cmp_lhs;
  logic [VEC_W-1:0] cmp_rhs;
  logic [VEC_W-1:0] size_mask [NUM_SIZES];
  logic [VEC_W-1:0] sel_mask;
  logic [VEC_W-1:0] kept_c;
  logic [VEC_W-1:0] kept_d;
  logic [VEC_W-1:0] merged;

  assign eq_mode = op_is_eq(cmp_op);
  assign swap_ab = op_swaps(cmp_op);
  assign cmp_lhs = swap_ab ? op_b : op_a;
  assign cmp_rhs = swap_ab ? op_a : op_b;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    csel_lane_cmp #(
      .VEC_W (VEC_W),
      .LANE_W(BASE_LANE_W << k)
    ) u_cmp (
      .lhs    (cmp_lhs),
      .rhs    (cmp_rhs),
      .eq_mode(eq_mode),
      .mask   (size_mask[k])
    );
  end

  always_comb begin
    unique case (lane_sz)
      SZ_BYTE: sel_mask = size_mask[0];
      SZ_HALF: sel_mask = size_mask[1];
      default: sel_mask = size_mask[2];
    endcase
  end

  csel_mask_merge #(.VEC_W(VEC_W)) u_merge (
    .mask  (sel_mask),
    .val_c (op_c),
    .val_d (op_d),
    .kept_c(kept_c),
    .kept_d(kept_d),
    .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_res   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mask <= sel_mask;
        out_res  <= merged;
      end
    end
  end

endmodule

// File: rtl/csel_unit_chk.sv
module csel_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [VEC_W-1:0] op_c,
  input logic [VEC_W-1:0] op_d,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_mask,
  input logic [VEC_W-1:0] out_res
);
  function automatic logic bytes_uniform(input logic [VEC_W-1:0] v);
    for (int i = 0; i < VEC_W/8; i++) begin
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
    end
    return 1'b1;
  endfunction

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_mask == '0 && out_res == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_mask_uniform: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> bytes_uniform(out_mask));

  a_r7_c_in_set_bits: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_res & out_mask) == ($past(op_c) & out_mask)));

  a_r8_d_in_clear_bits: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_res & ~out_mask) == ($past(op_d) & ~out_mask)));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_mask) && $stable(out_res)));

endmodule

bind csel_unit csel_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_c     (op_c),
  .op_d     (op_d),
  .out_valid(out_valid),
  .out_mask (out_mask),
  .out_res  (out_res)
);

// File: tb/csel_unit_test.sv
module csel_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   lane_sz = '0;
  logic [1:0]   cmp_op = '0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
  logic         out_valid;
  logic [W-1:0] out_mask, out_res;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  csel_unit #(.VEC_W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_sz(lane_sz),
    .cmp_op(cmp_op), .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .out_valid(out_valid), .out_mask(out_mask), .out_res(out_res)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // expected mask by integer arithmetic on each lane
  function automatic logic [W-1:0] model_mask(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic [1:0] sz, input logic [1:0] op);
    longint w, full, va, vb, res;
    logic hit;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    full = longint'(1) << w;
    res  = 0;
    for (int l = 0; l < W / int'(w); l++) begin
      va = (longint'(a) >> (l * w)) % full;
      vb = (longint'(b) >> (l * w)) % full;
      if (va >= full / 2) va = va - full;
      if (vb >= full / 2) vb = vb - full;
      case (op)
        2'd1:    hit = va > vb;
        2'd2:    hit = va < vb;
        default: hit = va == vb;
      endcase
      if (hit) res = res + ((full - 1) << (l * w));
    end
    return res[W-1:0];
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] sz, input logic [1:0] op,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] em;
    @(negedge clk);
    in_valid = 1'b1; lane_sz = sz; cmp_op = op;
    op_a = a; op_b = b; op_c = c; op_d = d;
    em = model_mask(a, b, sz, op);
    @(negedge clk);
    check("R2 out_valid", W'(out_valid), W'(1));
    // R3 R4 R5 R6 R10 mask per lane
    check((op == 2'd1) ? "R5 mask" : (op == 2'd2) ? "R6 mask" : "R4 mask", out_mask, em);
    // R7 R8 merged result
    check("R7 R8 result", out_res, (c & em) | (d & ~em));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] ha, hb, hm, hr;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", W'(out_valid), W'(0));
    check("R1 out_mask", out_mask, '0);
    check("R1 out_res", out_res, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 4; o++) begin
        // sign boundaries and equal low halves with differing high parts
        run_one(2'(s), 2'(o), 32'h7F80_00FF, 32'h8001_00FF, 32'hCCCC_CCCC, 32'h5555_5555);
        run_one(2'(s), 2'(o), 32'h8000_7FFF, 32'h7FFF_8000, 32'hA1B2_C3D4, 32'h1122_3344);
        run_one(2'(s), 2'(o), 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000);
        run_one(2'(s), 2'(o), 32'h1234_00FF, 32'h1235_00FF, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        for (int n = 0; n < 120; n++) begin
          logic [W-1:0] a, b, c, d, sel;
          seed = next_rand(seed); a = seed;
          seed = next_rand(seed); b = seed;
          seed = next_rand(seed); c = seed;
          seed = next_rand(seed); d = seed;
          seed = next_rand(seed); sel = seed;
          for (int i = 0; i < 4; i++) if (sel[i]) b[i*8 +: 8] = a[i*8 +: 8];
          if (sel[4]) b = a;
          run_one(2'(s), 2'(o), a, b, c, d);
        end
      end
    end

    // R9 idle cycles leave outputs untouched while inputs move
    run_one(2'd0, 2'd1, 32'h0102_8004, 32'h0101_7F05, 32'h1111_1111, 32'h2222_2222);
    ha = out_mask; hb = out_res;
    @(negedge clk);
    in_valid = 1'b0; lane_sz = 2'd2; cmp_op = 2'd0;
    op_a = 32'h5; op_b = 32'h5; op_c = 32'hFFFF_FFFF; op_d = 32'h0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      hm = out_mask; hr = out_res;
      check("R9 mask held", hm, ha);
      check("R9 result held", hr, hb);
      check("R2 out_valid low", W'(out_valid), W'(0));
      op_a = op_a + 32'h1;
    end

    // R1 reset mid-run
    run_one(2'd2, 2'd0, 32'h9, 32'h9, 32'hABCD_0123, 32'h0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R1 out_valid after rst", W'(out_valid), W'(0));
    check("R1 out_res after rst", out_res, '0);
    check("R1 out_mask after rst", out_mask, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule